// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider

This block divides a double-length magnitude by a single-length magnitude, with every operand in sign-magnitude form. The dividend arrives as an upper word and a lower word of `W` bits each plus one sign bit. The divisor is a `W`-bit magnitude plus its own sign bit. When a start pulse is accepted, the block captures all operands. It then compares the upper dividend word with the divisor. If the quotient could not fit in `W` bits, it raises a sticky overflow flag and ends at once. A zero divisor always takes this path.

Otherwise the block runs `W` iterations, and each iteration takes two clock cycles. In the first cycle the extension bit, the remainder word and the quotient word move left together by one place. In the second cycle the divisor is subtracted from the remainder word, and the difference is then kept or undone. The extension bit lets a `W`-bit subtractor produce a correct quotient bit even when the shifted partial remainder needs `W+1` bits.

A controller sets the order of operations. It moves through the states IDLE, CHECK, SHIFT, SUB and DONE. The transitions are named as follows:
- IDLE→CHECK on an accepted start.
- CHECK→DONE when the overflow test fails.
- CHECK→SHIFT when the overflow test passes.
- SHIFT→SUB always.
- SUB→SHIFT while steps remain.
- SUB→DONE after the last step.
- DONE→IDLE always.

Top module: `smag_divider`

## Requirements
- R1: With `busy` low, a high `start` is accepted on that rising edge, and `busy` is high from that edge until the edge that ends the `done` cycle.
- R2: If the upper dividend word is greater than or equal to the divisor magnitude, `ovf` and `done` rise together on the first rising edge after the accepting edge.
- R3: A divisor magnitude of zero always takes the overflow path of R2.
- R4: Without overflow, `done` rises on the (2·W+1)-th rising edge after the accepting edge. At that point `quo_mag` equals the floor of (upper·2^W + lower) divided by the divisor, and `rem_mag` equals the remainder of that division.
- R5: `quo_sign` is the XOR of the two operand signs, and `rem_sign` equals the dividend sign. Both are valid while `done` is high and keep their values afterwards.
- R6: `done` is high for exactly one cycle, and `busy` falls on the edge that ends that cycle.
- R7: `ovf` is cleared only on an accepted start and set only by a failed overflow test. It holds its value at every other time.
- R8: After `done`, the quotient and remainder outputs keep their values until the next accepted start.
- R9: During reset, `busy`, `done` and `ovf` are all low.
- R10: A `start` pulse that arrives while `busy` is high is ignored, so the results come from the operands captured at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (taken only when not busy) |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvd_hi | input | W | Upper word of dividend magnitude |
| dvd_lo | input | W | Lower word of dividend magnitude |
| dsr_sign | input | 1 | Divisor sign (1 = negative) |
| dsr_mag | input | W | Divisor magnitude |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ovf | output | 1 | Sticky divide-overflow flag |
| quo_mag | output | W | Quotient magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_mag | output | W | Remainder magnitude |
| rem_sign | output | 1 | Remainder sign |

## Verification
The bench numbers each rising edge from the edge that accepts `start`. The overflow flag and `done` are due one edge later on the overflow path. On the normal path `done`, the quotient and the remainder are due 2·W+1 edges later, and `busy` falls one edge after `done`. A behavioural model in the bench counts down this latency at every rising edge and recomputes the expected results with integer division. All outputs are compared with the model at each falling edge, so every sample is taken half a period after the edge that updates the design. The stimulus includes start pulses issued while the block is busy, and the model counts these as having no effect.

// File: rtl/smag_div_pkg.sv
package smag_div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SHIFT,
        ST_SUB,
        ST_DONE
    } div_state_e;

endpackage

// File: rtl/smag_div_ctrl.sv
module smag_div_ctrl
    import smag_div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hi_ge,
    output logic load,
    output logic shift_en,
    output logic sub_en,
    output logic busy,
    output logic done,
    output logic ovf
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);

    div_state_e state_q, state_d;
    logic [CW-1:0] steps_left;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: state_d = hi_ge ? ST_DONE : ST_SHIFT;
            ST_SHIFT: state_d = ST_SUB;
            ST_SUB:   state_d = (steps_left == CW'(1)) ? ST_DONE : ST_SHIFT;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        shift_en = 1'b0;
        sub_en   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy = 1'b0; load = start; end
            ST_CHECK: ;
            ST_SHIFT: shift_en = 1'b1;
            ST_SUB:   sub_en = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // step counter and sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_left <= '0;
            ovf        <= 1'b0;
        end else begin
            if (load) ovf <= 1'b0;
            else if (state_q == ST_CHECK && hi_ge) ovf <= 1'b1;
            if (state_q == ST_CHECK) steps_left <= STEPS;
            else if (sub_en)         steps_left <= steps_left - CW'(1);
        end
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r2_ovf_rises_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> done);

    a_r7_ovf_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ovf));

endmodule

// File: rtl/smag_div_datapath.sv
module smag_div_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift_en,
    input  logic         sub_en,
    input  logic         dvd_sign,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic         dsr_sign,
    input  logic [W-1:0] dsr_mag,
    output logic         hi_ge,
    output logic [W-1:0] a_o,
    output logic [W-1:0] q_o,
    output logic [W-1:0] b_o,
    output logic         qs_o,
    output logic         rs_o
);

    logic         e_q;
    logic [W-1:0] a_q, q_q, b_q;
    logic [W:0]   diff;
    logic [W-1:0] restored;

    // A plus two's complement of B; carry out means A >= B
    assign diff     = {1'b0, a_q} + {1'b0, ~b_q} + {{W{1'b0}}, 1'b1};
    assign restored = diff[W-1:0] + b_q;
    assign hi_ge    = diff[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q  <= 1'b0;
            a_q  <= '0;
            q_q  <= '0;
            b_q  <= '0;
            qs_o <= 1'b0;
            rs_o <= 1'b0;
        end else if (load) begin
            e_q  <= 1'b0;
            a_q  <= dvd_hi;
            q_q  <= dvd_lo;
            b_q  <= dsr_mag;
            qs_o <= dvd_sign ^ dsr_sign;
            rs_o <= dvd_sign;
        end else if (shift_en) begin
            {e_q, a_q, q_q} <= {a_q, q_q, 1'b0};
        end else if (sub_en) begin
            if (e_q) begin
                // partial remainder exceeds divisor; carry not copied to E
                a_q     <= diff[W-1:0];
                q_q[0]  <= 1'b1;
            end else if (diff[W]) begin
                a_q     <= diff[W-1:0];
                e_q     <= 1'b1;
                q_q[0]  <= 1'b1;
            end else begin
                a_q     <= restored;
                q_q[0]  <= 1'b0;
            end
        end
    end

    assign a_o = a_q;
    assign q_o = q_q;
    assign b_o = b_q;

endmodule

// File: rtl/smag_divider.sv
module smag_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dvd_sign,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic         dsr_sign,
    input  logic [W-1:0] dsr_mag,
    output logic         busy,
    output logic         done,
    output logic         ovf,
    output logic [W-1:0] quo_mag,
    output logic         quo_sign,
    output logic [W-1:0] rem_mag,
    output logic         rem_sign
);

    logic         load, shift_en, sub_en, hi_ge;
    logic [W-1:0] div_q;

    smag_div_ctrl #(.W(W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .hi_ge    (hi_ge),
        .load     (load),
        .shift_en (shift_en),
        .sub_en   (sub_en),
        .busy     (busy),
        .done     (done),
        .ovf      (ovf)
    );

    smag_div_datapath #(.W(W)) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .sub_en   (sub_en),
        .dvd_sign (dvd_sign),
        .dvd_hi   (dvd_hi),
        .dvd_lo   (dvd_lo),
        .dsr_sign (dsr_sign),
        .dsr_mag  (dsr_mag),
        .hi_ge    (hi_ge),
        .a_o      (rem_mag),
        .q_o      (quo_mag),
        .b_o      (div_q),
        .qs_o     (quo_sign),
        .rs_o     (rem_sign)
    );

    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> (rem_mag < div_q));

    a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_q == '0) |-> ovf);

endmodule

// File: tb/smag_divider_tb.sv
`timescale 1ns/1ps
module smag_divider_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dvd_sign = 1'b0, dsr_sign = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dsr_mag = '0;
    logic         busy, done, ovf, quo_sign, rem_sign;
    logic [W-1:0] quo_mag, rem_mag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    smag_divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_sign(dvd_sign), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
        .dsr_sign(dsr_sign), .dsr_mag(dsr_mag),
        .busy(busy), .done(done), .ovf(ovf),
        .quo_mag(quo_mag), .quo_sign(quo_sign),
        .rem_mag(rem_mag), .rem_sign(rem_sign)
    );

    // behavioural reference model
    bit m_busy, m_done, m_ovf, m_valid;
    int m_left;
    bit e_ovf, e_qs, e_rs;
    int e_q, e_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_valid = 0; m_left = 0;
        end else if (m_done) begin
            m_done = 0; m_busy = 0; m_valid = 1;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_done = 1;
                m_ovf  = e_ovf;
            end
        end else if (start) begin
            e_ovf = (int'(dvd_hi) >= int'(dsr_mag));
            e_qs  = dvd_sign ^ dsr_sign;
            e_rs  = dvd_sign;
            if (!e_ovf) begin
                e_q = (int'(dvd_hi) * (1 << W) + int'(dvd_lo)) / int'(dsr_mag);
                e_r = (int'(dvd_hi) * (1 << W) + int'(dvd_lo)) % int'(dsr_mag);
            end
            m_busy  = 1;
            m_ovf   = 0;
            m_valid = 0;
            m_left  = e_ovf ? 1 : 2 * W + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R1 busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R6 done", int'(done), int'(m_done));
            chk(ovf == m_ovf, "R7 ovf", int'(ovf), int'(m_ovf));
            if (m_done || m_valid) begin
                chk(quo_sign == e_qs, "R5 quo_sign", int'(quo_sign), int'(e_qs));
                chk(rem_sign == e_rs, "R5 rem_sign", int'(rem_sign), int'(e_rs));
                if (!e_ovf) begin
                    chk(int'(quo_mag) == e_q, m_done ? "R4 quotient" : "R8 quotient held",
                        int'(quo_mag), e_q);
                    chk(int'(rem_mag) == e_r, m_done ? "R4 remainder" : "R8 remainder held",
                        int'(rem_mag), e_r);
                end
            end
        end
    end

    task automatic do_op(input bit sd, input int hi, input int lo,
                         input bit ss, input int dv, input bit poke);
        @(negedge clk);
        start = 1'b1; dvd_sign = sd; dsr_sign = ss;
        dvd_hi = W'(hi); dvd_lo = W'(lo); dsr_mag = W'(dv);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: disturbing start while busy
            repeat (3) @(negedge clk);
            start = 1'b1; dvd_hi = ~dvd_hi; dvd_lo = ~dvd_lo; dsr_mag = 8'd3;
            dvd_sign = ~dvd_sign;
            @(negedge clk);
            start = 1'b0;
        end
        for (int g = 0; g < 100 && !done; g++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R9 done in reset", int'(done), 0);
        chk(ovf == 1'b0, "R9 ovf in reset", int'(ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 0, 100, 0, 7, 0);        // R4 plain
        do_op(1, 3, 8'h55, 0, 10, 0);     // R4 upper word nonzero, R5
        do_op(0, 9, 8'hFF, 1, 10, 0);     // R4 largest quotient
        do_op(1, 8'hFE, 8'hFF, 1, 8'hFF, 0); // R4 wide partial remainder (E path)
        do_op(0, 0, 200, 0, 1, 0);        // R4 divide by one
        do_op(0, 10, 0, 0, 10, 0);        // R2 equal upper word
        do_op(1, 50, 7, 0, 9, 0);         // R2 upper greater
        do_op(0, 0, 0, 1, 0, 0);          // R3 zero divisor, zero dividend
        do_op(1, 5, 5, 0, 0, 0);          // R3 zero divisor
        do_op(0, 0, 17, 0, 5, 0);         // R7 ovf cleared by new start
        do_op(0, 7, 8'hA3, 1, 200, 1);    // R10 start while busy ignored
        do_op(1, 0, 8'hFF, 1, 2, 1);      // R10 again
        repeat (5) @(negedge clk);        // R8 outputs hold

        for (int i = 0; i < 40; i++) begin
            int dv = int'($urandom_range(0, 255));
            int hi = int'($urandom_range(0, 255));
            if (dv != 0 && (i % 3) != 0) hi = hi % dv;
            do_op(bit'($urandom_range(0, 1)), hi, int'($urandom_range(0, 255)),
                  bit'($urandom_range(0, 1)), dv, bit'(i % 5 == 0 && hi < dv));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule